// File: doc/BRIEF.md
# Digital PLL NRZ Clock Recovery

This block rebuilds the bit timing of a serial non-return-to-zero stream that arrives as a one-bit level, sampled by a strobe that ticks at 32 times the nominal bit rate. A 16-bit phase accumulator acts as a numerically controlled oscillator. It advances by a fixed bias of 2048 on every tick, so with no correction it wraps once per nominal bit. Its top bit is the recovered clock.

At each tick where the input level differs from the stored level, the block treats the tick as a data transition. It takes the difference between a programmable target phase and the accumulator value as the phase error. A shift-only proportional-integral filter turns that error into a signed control word. The control word is added to the accumulator on every tick until the next transition, so long runs of identical bits keep the last correction.

The data bit is captured when the recovered clock rises. With the default target of a quarter turn (16384), the capture point falls about a quarter bit after each transition. A one-cycle strobe flags every captured bit.

Top module: `dpll_nrz_cdr`

## Requirements
- R1: After a synchronous active-high reset, rec_clk, bit_valid, bit_data and phase_err are all 0, and the accumulator, integrator, control word and stored level are cleared.
- R2: On each cycle with sample_en high, the accumulator becomes (accumulator + 2048 + control word) mod 2^16, using the control word as updated in that same cycle. On cycles with sample_en low, it holds. rec_clk is bit 15 of the accumulator.
- R3: A transition is a cycle with sample_en high and din different from the stored level. On a transition the stored level takes din. At all other times the stored level holds.
- R4: On a transition, phase_err becomes target_phase minus the accumulator value before the update, as a 17-bit two's-complement number. Otherwise phase_err holds.
- R5: On a transition, the integrator adds the phase error first. The control word then becomes (error >>> 6) + (new integrator >>> 9), using arithmetic shifts. Between transitions the control word holds.
- R6: The integrator is INT_W bits signed (default 32). It clamps at its most positive and most negative values instead of wrapping.
- R7: bit_valid goes high for exactly one clk cycle, in the cycle after a tick in which bit 15 of the accumulator goes from 0 to 1. In that cycle, bit_data holds the din value of that tick. bit_data holds its value between strobes.
- R8: With no transitions, the oscillator keeps running at its last corrected rate and keeps producing one strobe per accumulator wrap.
- R9: target_phase is an input that can be changed at run time. The new value applies from the next transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Oversample tick, one clk cycle wide |
| din | input | 1 | Oversampled NRZ level, already synchronised |
| target_phase | input | 16 | Desired accumulator phase at transitions |
| rec_clk | output | 1 | Recovered clock, accumulator MSB |
| bit_valid | output | 1 | One-cycle strobe per recovered bit |
| bit_data | output | 1 | Recovered data bit |
| phase_err | output | 17 | Signed phase error from the last transition |

## Verification
The assertions take for granted that din only matters on ticks and is already synchronised to clk. They also assume ticks never fall in two consecutive cycles in which the accumulator MSB would rise twice. That holds whenever the control word is small next to a half turn, because the accumulator then needs many ticks to wrap. The stimulus drives din and sample_en only between clock edges. It keeps the transmitted bit period within a few ticks of 32 and sends ticks either every cycle or every other cycle. A second instance with a narrow integrator is fed the same stream so that clamping happens on the first transition.

// File: rtl/dpll_nrz_cdr.sv
module dpll_nrz_cdr #(
  parameter int PHASE_W = 16,
  parameter int OSR     = 32,
  parameter int KP_SH   = 6,
  parameter int KI_SH   = 9,
  parameter int INT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sample_en,
  input  logic               din,
  input  logic [PHASE_W-1:0] target_phase,
  output logic               rec_clk,
  output logic               bit_valid,
  output logic               bit_data,
  output logic [PHASE_W:0]   phase_err
);
  localparam int EW = PHASE_W + 1;
  localparam int CW = ((INT_W > EW) ? INT_W : EW) + 1;
  localparam logic [PHASE_W-1:0] BIAS = PHASE_W'((64'd1 << PHASE_W) / OSR);
  localparam logic signed [CW-1:0] IMAX = CW'((64'sd1 <<< (INT_W - 1)) - 64'sd1);
  localparam logic signed [CW-1:0] IMIN = -IMAX - CW'(1);

  logic [PHASE_W-1:0]      acc_q, acc_nxt;
  logic                    lvl_q;
  logic signed [INT_W-1:0] integ_q, integ_nxt;
  logic signed [CW-1:0]    ctrl_q, ctrl_nxt, ctrl_use, integ_sum;
  logic signed [EW-1:0]    err_w;
  logic                    edge_w, rise_w;

  assign edge_w    = sample_en & (din ^ lvl_q);
  assign err_w     = $signed({1'b0, target_phase}) - $signed({1'b0, acc_q});
  assign integ_sum = CW'(integ_q) + CW'(err_w);

  always_comb begin
    if (integ_sum > IMAX)      integ_nxt = IMAX[INT_W-1:0];
    else if (integ_sum < IMIN) integ_nxt = IMIN[INT_W-1:0];
    else                       integ_nxt = integ_sum[INT_W-1:0];
  end

  assign ctrl_nxt = (CW'(err_w) >>> KP_SH) + (CW'(integ_nxt) >>> KI_SH);
  assign ctrl_use = edge_w ? ctrl_nxt : ctrl_q;
  assign acc_nxt  = acc_q + BIAS + ctrl_use[PHASE_W-1:0];
  assign rise_w   = sample_en & ~acc_q[PHASE_W-1] & acc_nxt[PHASE_W-1];
  assign rec_clk  = acc_q[PHASE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      lvl_q     <= 1'b0;
      integ_q   <= '0;
      ctrl_q    <= '0;
      phase_err <= '0;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      bit_valid <= rise_w;
      if (rise_w) bit_data <= din;
      if (sample_en) acc_q <= acc_nxt;
      if (edge_w) begin
        lvl_q     <= din;
        integ_q   <= integ_nxt;
        ctrl_q    <= ctrl_nxt;
        phase_err <= err_w;
      end
    end
  end

  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(acc_q));
  assert_level_R3: assert property (@(posedge clk) disable iff (rst)
    edge_w |=> lvl_q == $past(din));
  assert_err_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !edge_w |=> $stable(phase_err));
  assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !edge_w |=> $stable(ctrl_q));
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (edge_w && err_w > 0) |=> integ_q >= $past(integ_q));
  assert_strobe_width_R7: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);
  assert_strobe_rise_R7: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $rose(rec_clk));
  assert_strobe_data_R7: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> bit_data == $past(din));
endmodule

// File: tb/test_dpll_nrz_cdr.sv
module test_dpll_nrz_cdr;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic din = 1'b0;
  logic [15:0] target_phase = 16'd16384;
  logic rc [2];
  logic bv [2];
  logic bd [2];
  logic [16:0] pe [2];

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dpll_nrz_cdr i_dpll_nrz_cdr (
    .clk(clk), .rst(rst), .sample_en(sample_en), .din(din),
    .target_phase(target_phase), .rec_clk(rc[0]), .bit_valid(bv[0]),
    .bit_data(bd[0]), .phase_err(pe[0]));

  dpll_nrz_cdr #(.INT_W(12)) i_dpll_nrz_cdr_sat (
    .clk(clk), .rst(rst), .sample_en(sample_en), .din(din),
    .target_phase(target_phase), .rec_clk(rc[1]), .bit_valid(bv[1]),
    .bit_data(bd[1]), .phase_err(pe[1]));

  longint m_acc [2], m_int [2], m_ctl [2], m_err [2], lim [2];
  bit m_lvl [2], m_bv [2], m_bd [2];
  int strobes;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_acc[i] = 0; m_int[i] = 0; m_ctl[i] = 0; m_err[i] = 0;
      m_lvl[i] = 0; m_bv[i] = 0; m_bd[i] = 0;
    end
  endtask

  task automatic model_step(input bit en, input bit d);
    for (int i = 0; i < 2; i++) begin
      longint e, na;
      m_bv[i] = 0;
      if (en) begin
        if (d != m_lvl[i]) begin
          m_lvl[i] = d;
          e = longint'(target_phase) - m_acc[i];
          m_int[i] = m_int[i] + e;
          if (m_int[i] > lim[i]) m_int[i] = lim[i];
          if (m_int[i] < -lim[i] - 1) m_int[i] = -lim[i] - 1;
          m_ctl[i] = (e >>> 6) + (m_int[i] >>> 9);
          m_err[i] = e;
        end
        na = (m_acc[i] + 2048 + m_ctl[i]) & 64'hFFFF;
        m_bv[i] = (m_acc[i] < 32768) && (na >= 32768);
        if (m_bv[i]) m_bd[i] = d;
        m_acc[i] = na;
      end
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < 2; i++) begin
      string tag;
      tag = (i == 1) ? "R6" : "R2";
      check(rc[i] == (m_acc[i] >= 32768), tag, longint'(rc[i]), longint'(m_acc[i] >= 32768));
      check(longint'($signed(pe[i])) == m_err[i], (i == 1) ? "R6" : "R4",
            longint'($signed(pe[i])), m_err[i]);
      check(bv[i] == m_bv[i], "R7", longint'(bv[i]), longint'(m_bv[i]));
      check(bd[i] == m_bd[i], "R7", longint'(bd[i]), longint'(m_bd[i]));
      if (i == 0 && bv[i]) strobes++;
    end
  endtask

  task automatic cycle(input bit en, input bit d);
    sample_en = en; din = d;
    model_step(en, d);
    @(posedge clk);
    #(CLK_P/4);
    compare_all();
    @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int ticks, input int gap);
    for (int t = 0; t < ticks; t++) begin
      for (int g = 0; g < gap; g++) cycle(1'b0, b);
      cycle(1'b1, b);
    end
  endtask

  task automatic send_stream(input int nbits, input int ticks, input int gap, inout logic [15:0] lfsr);
    for (int k = 0; k < nbits; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send_bit(lfsr[0], ticks, gap);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lim[0] = (64'sd1 <<< 31) - 1;
    lim[1] = (64'sd1 <<< 11) - 1;
    lfsr = 16'hACE1;
    model_reset();
    @(negedge clk);
    rst = 1'b1; din = 1'b1; sample_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset even with active inputs
    for (int i = 0; i < 2; i++) begin
      check(rc[i] == 0, "R1", longint'(rc[i]), 0);
      check(bv[i] == 0, "R1", longint'(bv[i]), 0);
      check(bd[i] == 0, "R1", longint'(bd[i]), 0);
      check(pe[i] == 0, "R1", longint'(pe[i]), 0);
    end
    rst = 1'b0; sample_en = 1'b0; din = 1'b0;
    // R2 R3 R4 R5 R6: ticks every cycle, nominal period, first edge saturates narrow integrator
    send_bit(1'b1, 32, 0);
    send_stream(200, 32, 0, lfsr);
    // R8: long run with no transitions must keep strobing once per bit
    strobes = 0;
    send_bit(~din, 32, 0);
    strobes = 0;
    send_bit(din, 32 * 20, 0);
    check(strobes >= 19 && strobes <= 21, "R8", longint'(strobes), 20);
    // R2: idle cycles between ticks, faster transmitter
    send_stream(100, 31, 1, lfsr);
    // R9: new target phase, slower transmitter
    target_phase = 16'h8000;
    send_stream(100, 33, 0, lfsr);
    send_bit(~din, 32, 0);
    check(($signed(pe[0]) > -8192) && ($signed(pe[0]) < 8192), "R9",
          longint'($signed(pe[0])), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule